// File: doc/BRIEF.md
# Thread-Interleaved Issue Scheduler

This block shares one processor pipeline among many hardware thread contexts. Each context models one core of the target machine. The pipeline has five stages: fetch, decode, register access, memory and exception. On every host cycle the scheduler hands the pipeline one slot, and the slots go to the contexts in a fixed rotation. Each context gets one slot every `NUM_THREADS` host cycles. A context therefore never has two instructions in adjacent stages, and the pipeline needs no forwarding network.

A separate timing model decides how many target cycles an operation costs. It orders a context to wait by sending a stall request that carries a cycle count. That count drains only on the global target-cycle tick, so target time advances independently of host cycles. When the slot of a waiting context comes up, the scheduler issues a bubble. Each context keeps two counters for introspection: instructions issued and target cycles spent stalled. Both counters, and the stall cycles still left, can be read through a combinational read port indexed by thread number.

Each context runs a two-state machine. `T_READY` means no stall is pending, and `T_STALL` means stall cycles remain. The transitions are:
- `LOAD`: `T_READY` or `T_STALL` to `T_STALL`, taken on a request with a nonzero count.
- `DRAIN`: `T_STALL` to `T_STALL`, taken on a tick that leaves cycles remaining.
- `RELEASE`: `T_STALL` to `T_READY`, taken on the tick that consumes the last cycle.
- `IDLE`: the state is held otherwise.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset, the rotation points at thread 0, every thread is ready with zero remaining stall, and all issued and stalled counters read zero.
- R2: `issue_tid` advances by one on every host clock edge, wrapping from `NUM_THREADS-1` to 0, whether or not the slot issues.
- R3: `issue_valid` is 1 exactly when the thread in the current slot has zero remaining stall cycles. Otherwise the slot is a bubble, with `issue_valid` 0 and `issue_tid` still naming the slot's thread.
- R4: A stall request with a nonzero count loads that count as the remaining stall of thread `stall_tid` at the clock edge. A request with count zero changes nothing.
- R5: On an edge where `target_tick` is 1, every thread with nonzero remaining stall and no load at that edge decrements by one. Edges without a tick leave the remaining count unchanged.
- R6: If a thread receives a load and a tick at the same edge, the load wins and the remaining stall becomes the full requested count.
- R7: A thread's issued counter increments by one at each edge where its slot issues with `issue_valid` 1.
- R8: A thread's stalled counter increments by one at each edge where `target_tick` is 1 and the thread's remaining stall was nonzero before that edge.
- R9: `rd_issued`, `rd_stalled` and `rd_remaining` show the state of thread `rd_tid` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_valid | input | 1 | Stall request strobe |
| stall_tid | input | TID_W | Thread the stall request targets |
| stall_cycles | input | STALL_W | Target cycles to stall; zero means no request |
| target_tick | input | 1 | One target cycle has elapsed |
| issue_valid | output | 1 | Current slot issues an instruction |
| issue_tid | output | TID_W | Thread owning the current slot |
| rd_tid | input | TID_W | Thread selected for readout |
| rd_issued | output | CNT_W | Instructions issued by the selected thread |
| rd_stalled | output | CNT_W | Target cycles the selected thread spent stalled |
| rd_remaining | output | STALL_W | Stall cycles still pending for the selected thread |

## Verification
The bench builds the block with 4 threads, a 4-bit stall count and 16-bit counters. With 4 threads the rotation wraps every four cycles, so stall loads can be swept for every thread and every count from 0 to 3, and each counter can be read back after each sweep. This small configuration also puts the cases R5 and R6 describe within a few cycles of one another. Those cases are sparse ticks that stretch a stall over many host cycles, and a load that meets a tick on a thread that is already stalled.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

    typedef enum logic {
        T_READY = 1'b0,
        T_STALL = 1'b1
    } thr_state_e;

endpackage

// File: rtl/slot_rotator.sv
module slot_rotator #(
    parameter int NUM_THREADS = 64,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] slot
);
    localparam logic [TID_W-1:0] LAST = TID_W'(NUM_THREADS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)            slot <= '0;
        else if (slot == LAST) slot <= '0;
        else                   slot <= slot + 1'b1;
    end

    // R2: the slot steps by one every host cycle and wraps at the last thread
    a_r2_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(slot) == LAST) ? (slot == '0) : (slot == $past(slot) + 1'b1)));

endmodule

// File: rtl/thread_context.sv
module thread_context
    import thread_sched_pkg::*;
#(
    parameter int STALL_W = 16,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [STALL_W-1:0] load_val,
    input  logic               tick,
    input  logic               slot_hit,
    output logic               ready,
    output logic [STALL_W-1:0] remaining,
    output logic [CNT_W-1:0]   issued,
    output logic [CNT_W-1:0]   stalled
);
    thr_state_e state, state_nx;
    logic       issue_now;
    logic       drain_now;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= T_READY;
        else        state <= state_nx;
    end

    // transitions: LOAD, DRAIN, RELEASE, IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            T_READY: if (load_en) state_nx = T_STALL;
            T_STALL: begin
                if (load_en)                         state_nx = T_STALL;
                else if (tick && remaining == 'd1)   state_nx = T_READY;
                else                                 state_nx = T_STALL;
            end
            default: state_nx = T_READY;
        endcase
    end

    // outputs and counters
    always_comb begin
        ready     = (state == T_READY);
        issue_now = slot_hit && ready;
        drain_now = tick && (state == T_STALL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            issued    <= '0;
            stalled   <= '0;
        end else begin
            if (load_en)        remaining <= load_val;
            else if (drain_now) remaining <= remaining - 1'b1;
            if (issue_now)      issued    <= issued + 1'b1;
            if (drain_now)      stalled   <= stalled + 1'b1;
        end
    end

    // R3: the state machine and the remaining count agree
    a_r3_state_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_READY) == (remaining == '0));

    // R5: a tick without a load drains one cycle
    a_r5_tick_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && remaining != '0) |=> (remaining == $past(remaining) - 1'b1));

    // R5: no tick and no load keeps the count
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(remaining));

    // R4, R6: a load sets the full requested count even when a tick coincides
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (remaining == $past(load_val)));

    // R7: an issuing slot bumps the issued counter
    a_r7_issue_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_hit && remaining == '0) |=> (issued == $past(issued) + 1'b1));

    // R8: a tick on a stalled thread bumps the stalled counter
    a_r8_stall_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && remaining != '0) |=> (stalled == $past(stalled) + 1'b1));

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
    parameter int NUM_THREADS = 64,
    parameter int STALL_W     = 16,
    parameter int CNT_W       = 32,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_valid,
    input  logic [TID_W-1:0]   stall_tid,
    input  logic [STALL_W-1:0] stall_cycles,
    input  logic               target_tick,
    output logic               issue_valid,
    output logic [TID_W-1:0]   issue_tid,
    input  logic [TID_W-1:0]   rd_tid,
    output logic [CNT_W-1:0]   rd_issued,
    output logic [CNT_W-1:0]   rd_stalled,
    output logic [STALL_W-1:0] rd_remaining
);
    logic [TID_W-1:0]   slot;
    logic               thr_ready [NUM_THREADS];
    logic [STALL_W-1:0] thr_rem   [NUM_THREADS];
    logic [CNT_W-1:0]   thr_iss   [NUM_THREADS];
    logic [CNT_W-1:0]   thr_stl   [NUM_THREADS];

    slot_rotator #(.NUM_THREADS(NUM_THREADS)) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic load_hit;
        logic slot_hit;
        always_comb begin
            load_hit = stall_valid && (stall_tid == TID_W'(t)) && (stall_cycles != '0);
            slot_hit = (slot == TID_W'(t));
        end

        thread_context #(.STALL_W(STALL_W), .CNT_W(CNT_W)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_hit),
            .load_val  (stall_cycles),
            .tick      (target_tick),
            .slot_hit  (slot_hit),
            .ready     (thr_ready[t]),
            .remaining (thr_rem[t]),
            .issued    (thr_iss[t]),
            .stalled   (thr_stl[t])
        );
    end

    always_comb begin
        issue_tid    = slot;
        issue_valid  = thr_ready[slot];
        rd_issued    = thr_iss[rd_tid];
        rd_stalled   = thr_stl[rd_tid];
        rd_remaining = thr_rem[rd_tid];
    end

    // R3: a valid issue never belongs to a thread with pending stall
    a_r3_no_issue_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (thr_rem[issue_tid] == '0));

endmodule

// File: tb/thread_issue_sched_test.sv
`timescale 1ns/1ps
module thread_issue_sched_test;
    localparam int N  = 4;
    localparam int SW = 4;
    localparam int CW = 16;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall_valid = 1'b0;
    logic [TW-1:0] stall_tid = '0;
    logic [SW-1:0] stall_cycles = '0;
    logic          target_tick = 1'b0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [TW-1:0] rd_tid = '0;
    logic [CW-1:0] rd_issued;
    logic [CW-1:0] rd_stalled;
    logic [SW-1:0] rd_remaining;

    int checks = 0;
    int errors = 0;
    int m_ptr = 0;
    int m_rem [N];
    int m_iss [N];
    int m_stl [N];

    always #4 clk = ~clk;

    thread_issue_sched #(.NUM_THREADS(N), .STALL_W(SW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .stall_valid(stall_valid), .stall_tid(stall_tid), .stall_cycles(stall_cycles),
        .target_tick(target_tick),
        .issue_valid(issue_valid), .issue_tid(issue_tid),
        .rd_tid(rd_tid), .rd_issued(rd_issued), .rd_stalled(rd_stalled),
        .rd_remaining(rd_remaining)
    );

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a negative edge: check slot, drive, advance one host cycle
    task automatic step(bit sv, int stid, int scyc, bit tk);
        expect_eq("R2 issue_tid", int'(issue_tid), m_ptr);
        expect_eq("R3 issue_valid", int'(issue_valid), (m_rem[m_ptr] == 0) ? 1 : 0);
        stall_valid  = sv;
        stall_tid    = TW'(stid);
        stall_cycles = SW'(scyc);
        target_tick  = tk;
        @(posedge clk);
        if (m_rem[m_ptr] == 0) m_iss[m_ptr]++;
        for (int t = 0; t < N; t++) begin
            if (tk && m_rem[t] != 0) m_stl[t]++;
            if (sv && stid == t && scyc != 0) m_rem[t] = scyc;
            else if (tk && m_rem[t] != 0) m_rem[t]--;
        end
        m_ptr = (m_ptr + 1) % N;
        @(negedge clk);
        stall_valid = 1'b0;
        target_tick = 1'b0;
    endtask

    // read back every thread through the port, same cycle (R9)
    task automatic check_all(string tag);
        for (int t = 0; t < N; t++) begin
            rd_tid = TW'(t);
            #0.4;
            expect_eq({tag, " R9 R7 issued"},   int'(rd_issued),    m_iss[t]);
            expect_eq({tag, " R9 R8 stalled"},  int'(rd_stalled),   m_stl[t]);
            expect_eq({tag, " R9 R5 remaining"}, int'(rd_remaining), m_rem[t]);
        end
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < N; t++) begin
            m_rem[t] = 0; m_iss[t] = 0; m_stl[t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_eq("R1 issue_tid", int'(issue_tid), 0);
        expect_eq("R1 issue_valid", int'(issue_valid), 1);
        check_all("R1");

        // R2 R3 R7: free rotation
        for (int i = 0; i < 9; i++) step(0, 0, 0, 0);
        check_all("R7 idle");

        // R4 R5 R8: sweep every thread and count, including zero
        for (int t = 0; t < N; t++) begin
            for (int c = 0; c < 4; c++) begin
                step(1, t, c, 0);
                check_all("R4 load");
                for (int k = 0; k < 5; k++) step(0, 0, 0, 1);
                check_all("R5 drained");
            end
        end

        // R5: sparse ticks stretch the stall over host time
        step(1, 2, 5, 0);
        for (int k = 0; k < 15; k++) begin
            step(0, 0, 0, (k % 3) == 2);
            if (k == 7) check_all("R5 sparse");
        end
        check_all("R5 sparse end");

        // R6: load meets tick on an already stalled thread
        step(1, 1, 4, 0);
        step(0, 0, 0, 1);
        step(1, 1, 3, 1);
        check_all("R6 load wins");
        // R4: zero count on a stalled thread changes nothing
        step(1, 1, 0, 0);
        check_all("R4 zero ignored");
        for (int k = 0; k < 8; k++) step(0, 0, 0, 1);
        check_all("R8 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule